// File: doc/BRIEF.md
# Authenticated-Mode Entry and Exit Sequencer

This block sits beside a processor's branch path and controls when the core may run in a trusted execution mode. It keeps a protected-region descriptor (a base address and a size in bytes), an expected-signature register, and a saved signature. Software loads these through write ports while the core is in normal mode.

A branch whose target falls anywhere inside the region starts an entry attempt. The block asks an external MAC engine, through a request/done handshake, to authenticate the region. It then compares the engine's result with the expected signature. On an exact match the core enters secure mode and the program counter is redirected to the region base, wherever the branch was aimed. On a mismatch the block flags the failure for one cycle and lets the original branch proceed in normal mode. While a MAC is outstanding, further branches are held off through a ready/valid handshake.

Leaving secure mode is policed. Software must first write the mode-control exit register. A fetch outside the region without that write halts the core until reset. A signature-clear command wipes the saved signature that later signing operations would use.

Top module: `auth_mode_ctrl`

## Requirements
- R1: After reset the block is in normal mode. secure_o=0, halted_o=0, br_ready_o=1, mac_req_o=0, auth_fail_o=0, redir_valid_o=0, saved_sig_o=0, and the descriptor and expected signature are 0.
- R2: In normal mode, a branch that is accepted with a target t where base <= t < base+size raises mac_req_o in the next cycle. mac_req_o then stays high until the cycle after mac_done_i. A branch outside the region, or any branch when size is 0, leaves mac_req_o low.
- R3: While mac_req_o is high, br_ready_o is 0 and offered branches have no effect.
- R4: If mac_done_i arrives with mac_result_i equal to the expected signature, then in the next cycle secure_o=1, and redir_valid_o pulses for one cycle with redir_addr_o equal to the region base, whatever the branch target was. In the same cycle saved_sig_o takes the MAC result.
- R5: If mac_done_i arrives with a different result, then in the next cycle the block is back in normal mode. auth_fail_o pulses for one cycle, and redir_valid_o pulses with redir_addr_o equal to the original branch target.
- R6: In secure mode, a write to the exit register arms a permit. A valid fetch outside the region then returns the block to normal mode in the next cycle and consumes the permit. An exit write in the same cycle as that fetch also counts.
- R7: In secure mode, a valid fetch outside the region with no permit sets halted_o in the next cycle. In the halted state secure_o=0 and br_ready_o=0, and the block ignores every input until reset.
- R8: Exit writes made outside secure mode are ignored. A later secure session still halts if it leaves without its own exit write.
- R9: A command with opcode 8'hE0 clears saved_sig_o to 0 in the next cycle. Any other opcode leaves it unchanged.
- R10: Writes to the descriptor (seen on mac_base_o/mac_size_o) and to the expected signature take effect only in normal mode and are ignored in other states.
- R11: In secure mode, fetches inside the region change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_we_i | input | 1 | Load region descriptor |
| desc_base_i | input | AW | Region base address |
| desc_size_i | input | AW | Region size in bytes |
| sig_we_i | input | 1 | Load expected signature |
| sig_data_i | input | SW | Expected signature value |
| br_valid_i | input | 1 | Branch offered |
| br_ready_o | output | 1 | Branch accepted |
| br_target_i | input | AW | Branch target address |
| fetch_valid_i | input | 1 | Instruction fetch this cycle |
| fetch_addr_i | input | AW | Fetch address |
| exit_we_i | input | 1 | Write to mode-control exit register |
| cmd_valid_i | input | 1 | Crypto command strobe |
| cmd_op_i | input | 8 | Crypto command opcode |
| mac_req_o | output | 1 | MAC request to engine |
| mac_base_o | output | AW | Region base for engine |
| mac_size_o | output | AW | Region size for engine |
| mac_done_i | input | 1 | MAC result valid |
| mac_result_i | input | SW | MAC result |
| secure_o | output | 1 | Secure mode active |
| halted_o | output | 1 | Core halted by exit violation |
| auth_fail_o | output | 1 | One-cycle signature mismatch flag |
| redir_valid_o | output | 1 | PC redirect strobe |
| redir_addr_o | output | AW | PC redirect address |
| saved_sig_o | output | SW | Saved signature for signing |

## Verification
The bench targets the region boundaries: the last byte inside the region, the first byte past it, and an empty region. A design with an off-by-one compare would start MAC requests it should not, or miss exits it should catch. It offers branches during the MAC wait and changes the descriptor there; a block that accepted either would authenticate one region and then enter a different one. It checks that entry redirects to the base even when the branch aimed deeper. It checks that an exit write made in normal mode, or one already used by a previous exit, does not carry over, since a stale permit would let secure code leave without a halt. It also checks that a halted core ignores everything and that only opcode 0xE0 wipes the saved signature.

// File: rtl/auth_mode_ctrl.sv
module auth_mode_ctrl #(
  parameter int AW = 32,
  parameter int SW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_we_i,
  input  logic [AW-1:0] desc_base_i,
  input  logic [AW-1:0] desc_size_i,
  input  logic          sig_we_i,
  input  logic [SW-1:0] sig_data_i,
  input  logic          br_valid_i,
  output logic          br_ready_o,
  input  logic [AW-1:0] br_target_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          exit_we_i,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_op_i,
  output logic          mac_req_o,
  output logic [AW-1:0] mac_base_o,
  output logic [AW-1:0] mac_size_o,
  input  logic          mac_done_i,
  input  logic [SW-1:0] mac_result_i,
  output logic          secure_o,
  output logic          halted_o,
  output logic          auth_fail_o,
  output logic          redir_valid_o,
  output logic [AW-1:0] redir_addr_o,
  output logic [SW-1:0] saved_sig_o
);
  localparam logic [7:0] OP_SIGCLR = 8'hE0;

  typedef enum logic [1:0] {NORMAL, MAC_WAIT, SECURE, HALTED} state_t;

  state_t        state_q;
  logic [AW-1:0] base_q, size_q, tgt_q;
  logic [SW-1:0] exp_q, saved_q;
  logic          permit_q;

  logic br_in, fetch_out, br_take, permit_eff;

  assign br_in      = (br_target_i >= base_q) && ((br_target_i - base_q) < size_q);
  assign fetch_out  = fetch_valid_i &&
                      !((fetch_addr_i >= base_q) && ((fetch_addr_i - base_q) < size_q));
  assign br_ready_o = (state_q == NORMAL) || (state_q == SECURE);
  assign br_take    = br_valid_i && br_ready_o;
  assign permit_eff = permit_q || exit_we_i;

  assign mac_req_o   = (state_q == MAC_WAIT);
  assign mac_base_o  = base_q;
  assign mac_size_o  = size_q;
  assign secure_o    = (state_q == SECURE);
  assign halted_o    = (state_q == HALTED);
  assign saved_sig_o = saved_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= NORMAL;
      base_q        <= '0;
      size_q        <= '0;
      tgt_q         <= '0;
      exp_q         <= '0;
      saved_q       <= '0;
      permit_q      <= 1'b0;
      auth_fail_o   <= 1'b0;
      redir_valid_o <= 1'b0;
      redir_addr_o  <= '0;
    end else begin
      auth_fail_o   <= 1'b0;
      redir_valid_o <= 1'b0;
      case (state_q)
        NORMAL: begin
          if (br_take && br_in) begin
            tgt_q   <= br_target_i;
            state_q <= MAC_WAIT;
          end
          if (desc_we_i) begin
            base_q <= desc_base_i;
            size_q <= desc_size_i;
          end
          if (sig_we_i) exp_q <= sig_data_i;
        end
        MAC_WAIT: begin
          if (mac_done_i) begin
            redir_valid_o <= 1'b1;
            if (mac_result_i == exp_q) begin
              state_q      <= SECURE;
              redir_addr_o <= base_q;
              saved_q      <= mac_result_i;
            end else begin
              state_q      <= NORMAL;
              auth_fail_o  <= 1'b1;
              redir_addr_o <= tgt_q;
            end
          end
        end
        SECURE: begin
          if (fetch_out) begin
            if (permit_eff) begin
              state_q  <= NORMAL;
              permit_q <= 1'b0;
            end else begin
              state_q <= HALTED;
            end
          end else if (exit_we_i) begin
            permit_q <= 1'b1;
          end
        end
        default: state_q <= HALTED;
      endcase
      if (state_q != HALTED && cmd_valid_i && cmd_op_i == OP_SIGCLR)
        saved_q <= '0;
    end
  end
endmodule

// File: rtl/auth_mode_ctrl_chk.sv
module auth_mode_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          br_ready_o,
  input logic          mac_req_o,
  input logic          mac_done_i,
  input logic          secure_o,
  input logic          halted_o,
  input logic          auth_fail_o,
  input logic          redir_valid_o,
  input logic [AW-1:0] redir_addr_o,
  input logic [AW-1:0] mac_base_o
);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_req_o && !mac_done_i) |=> mac_req_o);
  assert_wait_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mac_req_o |-> !br_ready_o);
  assert_entry_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secure_o) |-> (redir_valid_o && redir_addr_o == mac_base_o));
  assert_fail_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    auth_fail_o |=> !auth_fail_o);
  assert_fail_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    auth_fail_o |-> (redir_valid_o && !secure_o));
  assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> (halted_o && !br_ready_o));
  assert_halt_not_secure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted_o && secure_o));
endmodule

bind auth_mode_ctrl auth_mode_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_ready_o(br_ready_o), .mac_req_o(mac_req_o),
  .mac_done_i(mac_done_i), .secure_o(secure_o), .halted_o(halted_o),
  .auth_fail_o(auth_fail_o), .redir_valid_o(redir_valid_o),
  .redir_addr_o(redir_addr_o), .mac_base_o(mac_base_o)
);

// File: tb/sim_auth_mode_ctrl.sv
`timescale 1ns/1ps
module sim_auth_mode_ctrl;
  localparam int AW = 32;
  localparam int SW = 64;

  logic clk = 0, rst_n = 0;
  logic desc_we = 0, sig_we = 0, br_valid = 0, fetch_valid = 0, exit_we = 0;
  logic cmd_valid = 0, mac_done = 0;
  logic [AW-1:0] desc_base = 0, desc_size = 0, br_target = 0, fetch_addr = 0;
  logic [SW-1:0] sig_data = 0, mac_result = 0;
  logic [7:0] cmd_op = 0;
  logic br_ready, mac_req, secure, halted, auth_fail, redir_valid;
  logic [AW-1:0] mac_base, mac_size, redir_addr;
  logic [SW-1:0] saved_sig;

  always #5 clk = ~clk;

  auth_mode_ctrl #(.AW(AW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .desc_we_i(desc_we), .desc_base_i(desc_base),
    .desc_size_i(desc_size), .sig_we_i(sig_we), .sig_data_i(sig_data),
    .br_valid_i(br_valid), .br_ready_o(br_ready), .br_target_i(br_target),
    .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr), .exit_we_i(exit_we),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .mac_req_o(mac_req),
    .mac_base_o(mac_base), .mac_size_o(mac_size), .mac_done_i(mac_done),
    .mac_result_i(mac_result), .secure_o(secure), .halted_o(halted),
    .auth_fail_o(auth_fail), .redir_valid_o(redir_valid),
    .redir_addr_o(redir_addr), .saved_sig_o(saved_sig)
  );

  int vectors = 0, errors = 0;

  // behavioural reference: 0 normal, 1 waiting, 2 secure, 3 halted
  int m_st = 0;
  logic [AW-1:0] m_base = 0, m_size = 0, m_tgt = 0, m_raddr = 0;
  logic [SW-1:0] m_exp = 0, m_saved = 0;
  bit m_permit = 0, m_fail = 0, m_redir = 0;

  function automatic bit inside_rgn(logic [AW-1:0] a, logic [AW-1:0] b, logic [AW-1:0] s);
    longint unsigned lo = b, hi = longint'(b) + longint'(s), x = a;
    return (x >= lo) && (x < hi);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_base = 0; m_size = 0; m_tgt = 0; m_raddr = 0;
      m_exp = 0; m_saved = 0; m_permit = 0; m_fail = 0; m_redir = 0;
    end else begin
      m_fail = 0; m_redir = 0;
      if (m_st == 0) begin
        if (br_valid && inside_rgn(br_target, m_base, m_size)) begin
          m_tgt = br_target; m_st = 1;
        end
        if (desc_we) begin m_base = desc_base; m_size = desc_size; end
        if (sig_we) m_exp = sig_data;
      end else if (m_st == 1) begin
        if (mac_done) begin
          m_redir = 1;
          if (mac_result == m_exp) begin m_st = 2; m_raddr = m_base; m_saved = mac_result; end
          else begin m_st = 0; m_fail = 1; m_raddr = m_tgt; end
        end
      end else if (m_st == 2) begin
        if (fetch_valid && !inside_rgn(fetch_addr, m_base, m_size)) begin
          if (m_permit || exit_we) begin m_st = 0; m_permit = 0; end
          else m_st = 3;
        end else if (exit_we) m_permit = 1;
      end
      if (m_st_prev_not_halted() && cmd_valid && cmd_op == 8'hE0) m_saved = 0;
    end
  end

  bit m_was_halted = 0;
  always @(negedge clk) m_was_halted = (m_st == 3);
  function automatic bit m_st_prev_not_halted();
    return !m_was_halted;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(br_ready, (m_st == 0 || m_st == 2), "R3 br_ready");
    chk(mac_req, (m_st == 1), "R2 mac_req");
    chk(secure, (m_st == 2), "R4 secure");
    chk(halted, (m_st == 3), "R7 halted");
    chk(auth_fail, m_fail, "R5 auth_fail");
    chk(redir_valid, m_redir, "R4 redir_valid");
    if (m_redir) chk(redir_addr, m_raddr, "R4 redir_addr");
    chk(saved_sig, m_saved, "R9 saved_sig");
    chk(mac_base, m_base, "R10 mac_base");
    chk(mac_size, m_size, "R10 mac_size");
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    desc_we = 0; sig_we = 0; br_valid = 0; fetch_valid = 0; exit_we = 0;
    cmd_valid = 0; mac_done = 0;
  endtask

  task automatic branch(input logic [AW-1:0] t);
    br_valid = 1; br_target = t; tick();
  endtask

  task automatic mac(input logic [SW-1:0] r);
    mac_done = 1; mac_result = r; tick();
  endtask

  task automatic fetch(input logic [AW-1:0] a);
    fetch_valid = 1; fetch_addr = a; tick();
  endtask

  localparam logic [SW-1:0] GOOD = 64'hA5A5_1234_DEAD_BEEF;

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk({br_ready, mac_req, secure, halted, auth_fail, redir_valid}, 6'b100000, "R1 reset flags");
    chk(saved_sig, 0, "R1 reset saved_sig");
    chk(mac_size, 0, "R1 reset size");
    // R2 empty region: no MAC
    branch(32'h0);
    chk(mac_req, 0, "R2 empty region");
    desc_we = 1; desc_base = 32'h1000; desc_size = 32'h100;
    sig_we = 1; sig_data = GOOD;
    tick();
    branch(32'h0FFF);
    chk(mac_req, 0, "R2 below base");
    branch(32'h1100);
    chk(mac_req, 0, "R2 one past end");
    // mismatch path
    branch(32'h1080);
    chk(mac_req, 1, "R2 in region");
    br_valid = 1; br_target = 32'h1000;
    desc_we = 1; desc_base = 32'h5000; desc_size = 32'h10;
    sig_we = 1; sig_data = 64'h1;
    tick();
    chk(br_ready, 0, "R3 stalled");
    chk(mac_base, 32'h1000, "R10 desc ignored in wait");
    tick();
    chk(mac_req, 1, "R2 hold");
    mac(GOOD ^ 64'h1);
    chk(auth_fail, 1, "R5 fail flag");
    chk(redir_addr, 32'h1080, "R5 redirect target");
    tick();
    chk(auth_fail, 0, "R5 single pulse");
    // successful entry at last byte
    branch(32'h10FF);
    mac(GOOD);
    chk(secure, 1, "R4 secure");
    chk(redir_addr, 32'h1000, "R4 base redirect");
    chk(saved_sig, GOOD, "R4 saved");
    desc_we = 1; desc_base = 32'h7000; tick();
    chk(mac_base, 32'h1000, "R10 desc ignored in secure");
    fetch(32'h1010);
    fetch(32'h10FF);
    chk(secure, 1, "R11 inside fetch");
    cmd_valid = 1; cmd_op = 8'h12; tick();
    chk(saved_sig, GOOD, "R9 other opcode");
    cmd_valid = 1; cmd_op = 8'hE0; tick();
    chk(saved_sig, 0, "R9 clear");
    exit_we = 1; tick();
    fetch(32'h2000);
    chk(secure, 0, "R6 permitted exit");
    // R8 exit write in normal ignored; stale permit must not carry
    exit_we = 1; tick();
    branch(32'h1000);
    mac(GOOD);
    chk(secure, 1, "R4 re-entry");
    // same-cycle exit write counts (R6)
    exit_we = 1; fetch_valid = 1; fetch_addr = 32'h0FFF; tick();
    chk(secure, 0, "R6 same-cycle exit");
    branch(32'h1040);
    mac(GOOD);
    tick();
    fetch(32'h1100);
    chk(halted, 1, "R8 stale permit halts");
    chk(br_ready, 0, "R7 halted ready");
    branch(32'h1040);
    exit_we = 1; cmd_valid = 1; cmd_op = 8'hE0; tick();
    desc_we = 1; desc_base = 32'h9000; tick();
    chk(halted, 1, "R7 sticky");
    chk(mac_base, 32'h1000, "R7 desc frozen");
    chk(saved_sig, GOOD, "R7 saved frozen");
    rst_n = 0; tick(); rst_n = 1;
    chk(halted, 0, "R1 reset clears halt");
    tick();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule